// File: doc/BRIEF.md
# Interrupt Enable, Mask and Status Unit

This block holds the interrupt mask and the sticky interrupt status of a serial channel. Software never writes the mask as a whole: it writes ones to a set port to turn mask bits on and ones to a clear port to turn them off. Single-cycle event pulses from the transmit and receive logic are captured into the status register only where the mask bit is on. Software clears a status bit by writing a one to it, and one interrupt line reports whether any enabled status bit is pending.

A separate read-only view shows four raw FIFO condition levels directly, whatever the mask holds. This lets polling software see those conditions without taking interrupts. Access is through a simple single-cycle register port with a word address. Reads are combinational from the address.

Top module: `irq_mask_unit`

## Requirements
- R1: A write to word address 0 (set port) turns on every mask bit where the written data holds a one. Mask bits where the data holds a zero keep their value. The new mask can be read at word address 2 after the write cycle.
- R2: A write to word address 1 (clear port) turns off every mask bit where the written data holds a one. All other mask bits keep their value.
- R3: Reads of address 0 and of address 1 always return zero.
- R4: All registers share one bit layout: bit 0 receive trigger level, bit 1 receive FIFO empty, bit 2 receive FIFO full, bit 3 transmit FIFO empty, bit 4 transmit FIFO full, bit 5 overrun, bit 6 framing error, bit 7 parity error, bit 8 receive timeout. An event pulse on `evt_in[i]` sets status bit i (readable at address 3) on the next clock edge only if mask bit i is on. Otherwise the pulse is dropped.
- R5: Status bits are sticky. A write to address 3 clears each status bit where the data holds a one and leaves the other bits as they are.
- R6: If an enabled event and a clearing write hit the same status bit in the same cycle, the bit ends up set.
- R7: `irq` is a register. It equals the OR over all bits of (status AND mask) as they stood one clock edge earlier, so it rises one cycle after the status bit and falls one cycle after the status bit or the mask bit is cleared.
- R8: Writes to address 2 (mask view) and to address 4 (raw view) change no state.
- R9: Reads of address 4 return the raw levels at the current time, whatever the mask holds: receive trigger in bit 0, receive empty in bit 1, transmit empty in bit 3 and transmit full in bit 4. All other bits read zero. The raw levels never set status bits.
- R10: After reset the mask is at its reset value (zero by default), the status is zero and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_addr | input | ADDR_W (3) | Word address |
| reg_wdata | input | DATA_W (16) | Write data |
| reg_rdata | output | DATA_W (16) | Read data for `reg_addr` |
| evt_in | input | EVT_W (9) | Single-cycle event pulses, one per status bit |
| raw_rx_trig | input | 1 | Raw receive trigger level |
| raw_rx_empty | input | 1 | Raw receive FIFO empty level |
| raw_tx_empty | input | 1 | Raw transmit FIFO empty level |
| raw_tx_full | input | 1 | Raw transmit FIFO full level |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `reg_addr` and `reg_wdata` are stable and valid whenever `reg_wr` is high. They also assume that event pulses are clean synchronous values, because the status register samples them at every edge. The bench drives every input at the falling edge, holds each write strobe for exactly one cycle, and lowers events and the strobe together at the next falling edge. Because the single port allows only one write per cycle, a set and a clear of the mask never reach the mask register together. The mask logic still gives priority to the clear, and an assertion keeps watch on it.

// File: rtl/irq_mask_unit_pkg.sv
package irq_mask_unit_pkg;

   // word offsets of the register port
   localparam int unsigned OFF_SET = 0;
   localparam int unsigned OFF_CLR = 1;
   localparam int unsigned OFF_MSK = 2;
   localparam int unsigned OFF_STS = 3;
   localparam int unsigned OFF_RAW = 4;

   // shared bit layout of mask, status and raw view
   localparam int unsigned B_RX_TRIG  = 0;
   localparam int unsigned B_RX_EMPTY = 1;
   localparam int unsigned B_RX_FULL  = 2;
   localparam int unsigned B_TX_EMPTY = 3;
   localparam int unsigned B_TX_FULL  = 4;
   localparam int unsigned B_OVERRUN  = 5;
   localparam int unsigned B_FRAMING  = 6;
   localparam int unsigned B_PARITY   = 7;
   localparam int unsigned B_TIMEOUT  = 8;
   localparam int unsigned MIN_EVT    = 9;

   typedef enum logic [1:0] {
      RD_ZERO = 2'd0,
      RD_MSK  = 2'd1,
      RD_STS  = 2'd2,
      RD_RAW  = 2'd3
   } rd_sel_e;

endpackage

// File: rtl/irq_mask_unit_mask.sv
module irq_mask_unit_mask #(
   parameter int unsigned       W   = 9,
   parameter logic [W-1:0]      RST = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_en,
   input  logic [W-1:0] set_bits,
   input  logic         clr_en,
   input  logic [W-1:0] clr_bits,
   output logic [W-1:0] mask_q
);

   logic [W-1:0] set_v;
   logic [W-1:0] clr_v;
   logic [W-1:0] mask_d;

   assign set_v = set_en ? set_bits : '0;
   assign clr_v = clr_en ? clr_bits : '0;

   // clear applied after set, so a clear wins on a shared bit
   assign mask_d = (mask_q | set_v) & ~clr_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mask_q <= RST;
      else        mask_q <= mask_d;
   end

   AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (set_en && !clr_en) |=> ((mask_q & $past(set_bits)) == $past(set_bits))); // R1
   AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      clr_en |=> ((mask_q & $past(clr_bits)) == '0)); // R2
   AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!set_en && !clr_en) |=> $stable(mask_q)); // R8

endmodule

// File: rtl/irq_mask_unit_status.sv
module irq_mask_unit_status #(
   parameter int unsigned W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] evt,
   input  logic [W-1:0] mask,
   input  logic [W-1:0] clr,
   output logic [W-1:0] sts_q
);

   logic [W-1:0] hit;
   assign hit = evt & mask;

   for (genvar i = 0; i < W; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          sts_q[i] <= 1'b0;
         else if (hit[i])     sts_q[i] <= 1'b1;
         else if (clr[i])     sts_q[i] <= 1'b0;
      end
   end

   AST_STS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((sts_q & ~$past(sts_q)) & ~$past(mask)) == '0)); // R4
   AST_STS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(sts_q) & ~sts_q & ~$past(clr)) == '0)); // R5
   AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      ((evt & mask & clr) != '0) |=> ((sts_q & $past(evt & mask & clr)) == $past(evt & mask & clr))); // R6

endmodule

// File: rtl/irq_mask_unit_irq.sv
module irq_mask_unit_irq #(
   parameter int unsigned W       = 9,
   parameter bit          REG_OUT = 1'b1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] sts,
   input  logic [W-1:0] mask,
   output logic         irq
);

   logic pend;
   assign pend = |(sts & mask);

   if (REG_OUT) begin : g_reg
      logic irq_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) irq_q <= 1'b0;
         else        irq_q <= pend;
      end
      assign irq = irq_q;

      AST_IRQ_LAG: assert property (@(posedge clk) disable iff (!rst_n)
         1'b1 |=> (irq == $past(|(sts & mask)))); // R7
   end else begin : g_comb
      assign irq = pend;
   end

endmodule

// File: rtl/irq_mask_unit_rdmux.sv
module irq_mask_unit_rdmux
   import irq_mask_unit_pkg::*;
#(
   parameter int unsigned W      = 9,
   parameter int unsigned DATA_W = 16,
   parameter int unsigned ADDR_W = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [W-1:0]      mask,
   input  logic [W-1:0]      sts,
   input  logic [W-1:0]      raw,
   output logic [DATA_W-1:0] rdata
);

   rd_sel_e sel;

   always_comb begin
      unique case (addr)
         ADDR_W'(OFF_MSK): sel = RD_MSK;
         ADDR_W'(OFF_STS): sel = RD_STS;
         ADDR_W'(OFF_RAW): sel = RD_RAW;
         default:          sel = RD_ZERO;
      endcase
   end

   always_comb begin
      case (sel)
         RD_MSK:  rdata = DATA_W'(mask);
         RD_STS:  rdata = DATA_W'(sts);
         RD_RAW:  rdata = DATA_W'(raw);
         default: rdata = '0;
      endcase
   end

   AST_WO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      ((addr == ADDR_W'(OFF_SET)) || (addr == ADDR_W'(OFF_CLR))) |-> (rdata == '0)); // R3

endmodule

// File: rtl/irq_mask_unit.sv
module irq_mask_unit
   import irq_mask_unit_pkg::*;
#(
   parameter int unsigned   EVT_W    = 9,
   parameter int unsigned   DATA_W   = 16,
   parameter int unsigned   ADDR_W   = 3,
   parameter logic [EVT_W-1:0] MASK_RST = '0,
   parameter bit            IRQ_REG  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [EVT_W-1:0]  evt_in,
   input  logic              raw_rx_trig,
   input  logic              raw_rx_empty,
   input  logic              raw_tx_empty,
   input  logic              raw_tx_full,
   output logic              irq
);

   localparam int unsigned ADDR_SPAN = 1 << ADDR_W;

   if (EVT_W < MIN_EVT) begin : g_bad_evt
      $error("EVT_W must cover the shared bit layout");
   end
   if (DATA_W < EVT_W) begin : g_bad_data
      $error("DATA_W must be at least EVT_W");
   end
   if (ADDR_SPAN <= OFF_RAW) begin : g_bad_addr
      $error("ADDR_W too small for the register set");
   end

   logic [EVT_W-1:0] wbits;
   logic             wr_set, wr_clr, wr_sts;
   logic [EVT_W-1:0] sts_clr;
   logic [EVT_W-1:0] mask_q;
   logic [EVT_W-1:0] sts_q;
   logic [EVT_W-1:0] raw_vec;

   assign wbits  = reg_wdata[EVT_W-1:0];
   if (DATA_W > EVT_W) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^reg_wdata[DATA_W-1:EVT_W];
   end

   assign wr_set  = reg_wr && (reg_addr == ADDR_W'(OFF_SET));
   assign wr_clr  = reg_wr && (reg_addr == ADDR_W'(OFF_CLR));
   assign wr_sts  = reg_wr && (reg_addr == ADDR_W'(OFF_STS));
   assign sts_clr = wr_sts ? wbits : '0;

   always_comb begin
      raw_vec               = '0;
      raw_vec[B_RX_TRIG]    = raw_rx_trig;
      raw_vec[B_RX_EMPTY]   = raw_rx_empty;
      raw_vec[B_TX_EMPTY]   = raw_tx_empty;
      raw_vec[B_TX_FULL]    = raw_tx_full;
   end

   irq_mask_unit_mask #(.W(EVT_W), .RST(MASK_RST)) u_mask (
      .clk(clk), .rst_n(rst_n),
      .set_en(wr_set), .set_bits(wbits),
      .clr_en(wr_clr), .clr_bits(wbits),
      .mask_q(mask_q)
   );

   irq_mask_unit_status #(.W(EVT_W)) u_sts (
      .clk(clk), .rst_n(rst_n),
      .evt(evt_in), .mask(mask_q), .clr(sts_clr),
      .sts_q(sts_q)
   );

   irq_mask_unit_irq #(.W(EVT_W), .REG_OUT(IRQ_REG)) u_irq (
      .clk(clk), .rst_n(rst_n),
      .sts(sts_q), .mask(mask_q), .irq(irq)
   );

   irq_mask_unit_rdmux #(.W(EVT_W), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
      .clk(clk), .rst_n(rst_n), .addr(reg_addr),
      .mask(mask_q), .sts(sts_q), .raw(raw_vec),
      .rdata(reg_rdata)
   );

   AST_RST_QUIET: assert property (@(posedge clk) $rose(rst_n) |-> (sts_q == '0 && !irq)); // R10
   AST_RAW_NO_STS: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_in == '0 && !wr_sts) |=> $stable(sts_q)); // R9

endmodule

// File: tb/irq_mask_unit_test.sv
module irq_mask_unit_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic [8:0]  evt_in = '0;
   logic        raw_rx_trig = 1'b0, raw_rx_empty = 1'b0;
   logic        raw_tx_empty = 1'b0, raw_tx_full = 1'b0;
   logic        irq;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   irq_mask_unit uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_in(evt_in),
      .raw_rx_trig(raw_rx_trig), .raw_rx_empty(raw_rx_empty),
      .raw_tx_empty(raw_tx_empty), .raw_tx_full(raw_tx_full), .irq(irq)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   task automatic pulse(input logic [8:0] e);
      @(negedge clk);
      evt_in = e;
      @(negedge clk);
      evt_in = '0;
   endtask

   task automatic t_reset;
      logic [15:0] d;
      rd(3'd2, d); check("R10 mask", d, 16'h000);
      rd(3'd3, d); check("R10 status", d, 16'h000);
      check("R10 irq", 16'(irq), 16'h0);
   endtask

   task automatic t_set_clr;
      logic [15:0] d;
      wr(3'd0, 16'h005); rd(3'd2, d); check("R1 set", d, 16'h005);
      wr(3'd0, 16'h100); rd(3'd2, d); check("R1 keep zeros", d, 16'h105);
      wr(3'd1, 16'h004); rd(3'd2, d); check("R2 clear", d, 16'h101);
      rd(3'd0, d); check("R3 set port reads zero", d, 16'h000);
      rd(3'd1, d); check("R3 clear port reads zero", d, 16'h000);
   endtask

   task automatic t_gate;
      logic [15:0] d;
      pulse(9'h0FF);
      rd(3'd3, d); check("R4 gated capture", d, 16'h001);
      check("R7 irq lags status", 16'(irq), 16'h0);
      @(negedge clk);
      check("R7 irq rises", 16'(irq), 16'h1);
   endtask

   task automatic t_w1c;
      logic [15:0] d;
      wr(3'd0, 16'h1FF);
      pulse(9'h048);
      rd(3'd3, d); check("R5 accumulate", d, 16'h049);
      wr(3'd3, 16'h008); rd(3'd3, d); check("R5 w1c one bit", d, 16'h041);
      wr(3'd3, 16'h000); rd(3'd3, d); check("R5 zero write keeps", d, 16'h041);
      wr(3'd3, 16'h041); rd(3'd3, d); check("R5 clear all", d, 16'h000);
      @(negedge clk);
      check("R7 irq falls", 16'(irq), 16'h0);
   endtask

   task automatic t_set_wins;
      logic [15:0] d;
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = 3'd3; reg_wdata = 16'h040; evt_in = 9'h040;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0; evt_in = '0;
      rd(3'd3, d); check("R6 set beats clear", d, 16'h040);
      wr(3'd3, 16'h040); rd(3'd3, d); check("R6 cleared after", d, 16'h000);
   endtask

   task automatic t_ignored;
      logic [15:0] d;
      wr(3'd2, 16'h000); rd(3'd2, d); check("R8 mask view write", d, 16'h1FF);
      wr(3'd4, 16'h1FF); rd(3'd4, d); check("R8 raw view write", d, 16'h000);
      rd(3'd3, d); check("R8 status untouched", d, 16'h000);
   endtask

   task automatic t_raw;
      logic [15:0] d;
      wr(3'd1, 16'h1FF);
      @(negedge clk);
      raw_rx_trig = 1'b1; raw_tx_full = 1'b1;
      rd(3'd4, d); check("R9 raw trig/full", d, 16'h011);
      raw_rx_trig = 1'b0; raw_tx_full = 1'b0; raw_rx_empty = 1'b1; raw_tx_empty = 1'b1;
      rd(3'd4, d); check("R9 raw empties", d, 16'h00A);
      @(negedge clk);
      rd(3'd3, d); check("R9 no status from raw", d, 16'h000);
      raw_rx_empty = 1'b0; raw_tx_empty = 1'b0;
   endtask

   task automatic t_mask_drop;
      logic [15:0] d;
      wr(3'd0, 16'h080);
      pulse(9'h080);
      @(negedge clk);
      check("R7 irq on parity", 16'(irq), 16'h1);
      wr(3'd1, 16'h080);
      check("R7 irq one cycle after mask off", 16'(irq), 16'h1);
      @(negedge clk);
      check("R7 irq low after mask off", 16'(irq), 16'h0);
      rd(3'd3, d); check("R5 status held while masked", d, 16'h080);
      pulse(9'h100);
      rd(3'd3, d); check("R4 masked event dropped", d, 16'h080);
      wr(3'd3, 16'h080);
   endtask

   task automatic finish_run;
      if (!done) begin
         done = 1'b1;
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 4);
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_set_clr();
      t_gate();
      t_w1c();
      t_set_wins();
      t_ignored();
      t_raw();
      t_mask_drop();
      finish_run();
   end

endmodule